// File: doc/BRIEF.md
# Flash Busy-Status Reporter

This block stands in for the read path of a parallel NOR flash while an internal program or erase is under way. A one-cycle start pulse with an operation code, a target address and a data byte launches an operation. A busy timer then runs for a length set by parameters, with a separate length for each operation. While the timer runs, every read returns a status byte rather than array contents. Bit 7 is a polling bit: during a program it is the inverse of bit 7 of the byte being written, and during an erase it is 0. Bit 6 is a toggle bit that flips once for each read. The remaining bits are driven low.

When the timer expires, the operation is committed to a small register array that stands in for the flash cells. Reads then return array data again. A programmed location returns the written byte, and an erased region returns all ones. The read data path is combinational from the read address, so a host can poll status and read data through the same port. A start that arrives while an operation is running is ignored.

Top module: `nor_status_reporter`

## Requirements
- R1: After reset `busy_o` is low and every array location reads 8'hFF.
- R2: A start pulse taken while idle raises `busy_o` in the next cycle, and `busy_o` stays high for exactly the cycle count set for that operation. The operation codes are 0 for program, 1 for sector erase, 2 for block erase and 3 for chip erase.
- R3: A start pulse that arrives while `busy_o` is high has no effect. It does not change the busy length, the status byte or the committed array contents.
- R4: While a program is busy, bit 7 of `rdata_o` is the complement of bit 7 of the data byte latched at start.
- R5: While any erase is busy, bit 7 of `rdata_o` is 0.
- R6: In the first busy cycle, bit 6 of `rdata_o` is 0. It flips after each clock edge at which `busy_o` is high and `rd_i` has risen, meaning `rd_i` is 1 now and was 0 at the previous edge. Otherwise it holds.
- R7: While busy, bits 5 to 0 of `rdata_o` read 0, whatever the address.
- R8: When a program completes, the target location holds the written byte, and a read returns that byte, including its true bit 7.
- R9: A sector erase sets to 8'hFF every location whose address matches the target above the low SECT_AW bits. All other locations are unchanged.
- R10: A block erase sets to 8'hFF every location whose address matches the target above the low BLK_AW bits. All other locations are unchanged.
- R11: A chip erase sets every location to 8'hFF.
- R12: While idle, `rdata_o` equals the array word at `addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation code: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| addr_i | input | AW | Target address at start; read address otherwise |
| wdata_i | input | 8 | Byte to program, latched at start |
| rd_i | input | 1 | Read strobe; a rising edge advances the toggle bit while busy |
| rdata_o | output | 8 | Status byte while busy, array word while idle |
| busy_o | output | 1 | High while an internal operation runs |

## Verification
The bench builds the block with a 16-word array, 4-word sectors and 8-word blocks, and with busy lengths of 3, 5, 7 and 9 cycles for program, sector erase, block erase and chip erase. These sizes are small enough to program every location with a computed pattern and to read back the whole array after each operation. Each busy length can be counted cycle by cycle, and every status read in every busy window can be checked for its polling and toggle bits. The distinct lengths also make a start accepted by mistake in mid-operation show up as a wrong busy count and a wrong array word.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED = 8'hFF;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;
endpackage

// File: rtl/nsr_busy_timer.sv
module nsr_busy_timer
  import nsr_pkg::*;
#(
  parameter int T_PROG = 4,
  parameter int T_SECT = 6,
  parameter int T_BLK  = 8,
  parameter int T_CHIP = 10,
  localparam int T_MAX = (T_PROG > T_SECT ? T_PROG : T_SECT) > (T_BLK > T_CHIP ? T_BLK : T_CHIP)
                       ? (T_PROG > T_SECT ? T_PROG : T_SECT) : (T_BLK > T_CHIP ? T_BLK : T_CHIP),
  localparam int CNT_W = $clog2(T_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, dur;

  always_comb begin
    case (op_i)
      OP_PROG: dur = CNT_W'(T_PROG);
      OP_SECT: dur = CNT_W'(T_SECT);
      OP_BLK:  dur = CNT_W'(T_BLK);
      default: dur = CNT_W'(T_CHIP);
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = dur;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/nsr_toggle.sv
module nsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic rd_q, tog_q, tog_d, rd_rise;

  assign rd_rise = rd_i & ~rd_q;

  always_comb begin
    tog_d = tog_q;
    if (clear_i)
      tog_d = 1'b0;
    else if (busy_i && rd_rise)
      tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q  <= rd_i;
      tog_q <= tog_d;
    end
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/nsr_array_stub.sv
module nsr_array_stub
  import nsr_pkg::*;
#(
  parameter int AW      = 4,
  parameter int SECT_AW = 2,
  parameter int BLK_AW  = 3,
  localparam int DEPTH  = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  op_e               op_i,
  input  logic [AW-1:0]     op_addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [BYTE_W-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (commit_i) begin
        case (op_i)
          OP_PROG: if (i == int'(op_addr_i)) mem_d[i] = wdata_i;
          OP_SECT: if ((i >> SECT_AW) == (int'(op_addr_i) >> SECT_AW)) mem_d[i] = ERASED;
          OP_BLK:  if ((i >> BLK_AW) == (int'(op_addr_i) >> BLK_AW)) mem_d[i] = ERASED;
          default: mem_d[i] = ERASED;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (commit_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nor_status_reporter.sv
module nor_status_reporter
  import nsr_pkg::*;
#(
  parameter int AW      = 4,
  parameter int SECT_AW = 2,
  parameter int BLK_AW  = 3,
  parameter int T_PROG  = 4,
  parameter int T_SECT  = 6,
  parameter int T_BLK   = 8,
  parameter int T_CHIP  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o
);
  logic              accept, done, tog;
  op_e               op_q;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] wdata_q, arr_rdata;
  logic              poll_bit;

  assign accept = start_i & ~busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_PROG;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q    <= op_e'(op_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  nsr_busy_timer #(
    .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK), .T_CHIP(T_CHIP)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .op_i(op_e'(op_i)),
    .busy_o(busy_o), .done_o(done)
  );

  nsr_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .busy_i(busy_o),
    .rd_i(rd_i), .tog_o(tog)
  );

  nsr_array_stub #(
    .AW(AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .commit_i(done), .op_i(op_q),
    .op_addr_i(addr_q), .wdata_i(wdata_q), .raddr_i(addr_i),
    .rdata_o(arr_rdata)
  );

  assign poll_bit = (op_q == OP_PROG) ? ~wdata_q[BYTE_W-1] : 1'b0;

  always_comb begin
    if (busy_o)
      rdata_o = {poll_bit, tog, {(BYTE_W-2){1'b0}}};
    else
      rdata_o = arr_rdata;
  end
endmodule

// File: rtl/nor_status_reporter_chk.sv
module nor_status_reporter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] op_i,
  input logic [7:0] wdata_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       busy_o
);
  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R4
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(op_i) == 2'd0) |-> (rdata_o[7] == ~$past(wdata_i[7])));

  // R5
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(op_i) != 2'd0) |-> (rdata_o[7] == 1'b0));

  // R6
  tog_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (rdata_o[6] == 1'b0));

  // R6
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(rd_i)) |-> $stable(rdata_o[6]));

  // R7
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rdata_o[5:0] == 6'd0));
endmodule

bind nor_status_reporter nor_status_reporter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
  .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o), .busy_o(busy_o)
);

// File: tb/nor_status_reporter_test.sv
module nor_status_reporter_test;
  localparam int AW = 4, SECT_AW = 2, BLK_AW = 3, DEPTH = 16;
  localparam int TP = 3, TS = 5, TB = 7, TC = 9;

  logic       clk, rst_n, start_i, rd_i, busy_o;
  logic [1:0] op_i;
  logic [3:0] addr_i;
  logic [7:0] wdata_i, rdata_o;

  int total, bad, exp_mem[DEPTH];
  bit finished;

  nor_status_reporter #(
    .AW(AW), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW),
    .T_PROG(TP), .T_SECT(TS), .T_BLK(TB), .T_CHIP(TC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dur(input int op);
    case (op)
      0: return TP;
      1: return TS;
      2: return TB;
      default: return TC;
    endcase
  endfunction

  task automatic check_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      addr_i = 4'(a);
      #1;
      chk(rdata_o == 8'(exp_mem[a]), req, rdata_o, exp_mem[a]);
    end
  endtask

  // one operation; reads every other cycle when do_reads; optional second start mid-way (R3)
  task automatic run_op(input int op, input int a, input int d, input bit do_reads, input bit extra);
    int nr, cnt;
    bit prev;
    @(negedge clk);
    start_i = 1'b1; op_i = 2'(op); addr_i = 4'(a); wdata_i = 8'(d); rd_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    nr = 0; cnt = 0; prev = 1'b0;
    while (busy_o && cnt < 40) begin
      #1;
      if (op == 0) chk(rdata_o[7] == ~d[7], "R4", rdata_o[7], ~d[7]);
      else         chk(rdata_o[7] == 1'b0, "R5", rdata_o[7], 0);
      chk(rdata_o[6] == nr[0], "R6", rdata_o[6], nr[0]);
      chk(rdata_o[5:0] == 6'd0, "R7", rdata_o[5:0], 0);
      cnt++;
      rd_i = do_reads ? cnt[0] : 1'b0;
      if (rd_i && !prev) nr++;
      prev = rd_i;
      if (extra && cnt == 1) begin
        start_i = 1'b1; op_i = 2'(3 - op); addr_i = 4'(a ^ 5); wdata_i = 8'(~d);
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    rd_i = 1'b0;
    chk(cnt == dur(op), extra ? "R3" : "R2", cnt, dur(op));
    for (int i = 0; i < DEPTH; i++) begin
      case (op)
        0: if (i == a) exp_mem[i] = d & 8'hFF;
        1: if ((i >> SECT_AW) == (a >> SECT_AW)) exp_mem[i] = 8'hFF;
        2: if ((i >> BLK_AW) == (a >> BLK_AW)) exp_mem[i] = 8'hFF;
        default: exp_mem[i] = 8'hFF;
      endcase
    end
  endtask

  initial begin
    total = 0; bad = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; rd_i = 1'b0; op_i = 2'd0; addr_i = '0; wdata_i = '0;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy_o == 1'b0, "R1", busy_o, 0);
    check_all("R1");
    for (int a = 0; a < DEPTH; a++) run_op(0, a, (a * 53 + 17 + (a << 7)) & 8'hFF, 1'b1, 1'b0);
    check_all("R8 R12");
    run_op(1, 5, 0, 1'b1, 1'b0);
    check_all("R9");
    run_op(2, 9, 0, 1'b1, 1'b0);
    check_all("R10");
    run_op(0, 2, 8'h3C, 1'b1, 1'b1);
    check_all("R3");
    run_op(0, 12, 8'hA5, 1'b0, 1'b0);
    check_all("R8");
    run_op(2, 1, 0, 1'b0, 1'b0);
    check_all("R10");
    run_op(3, 6, 0, 1'b1, 1'b0);
    check_all("R11");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule